// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tag, permission and lock-owner state for every way of a small set-associative cache, along with a least-recently-used order for each set. A cache controller presents one line-aligned address per cycle together with an operation code. The directory answers each one on the following cycle with a hit flag, an error flag, a one-hot way vector and, for the two operations that return a line address, that address. The operations are permission-checked accesses, presence and space queries, allocation, deallocation, victim selection, lock handling, permission updates and a read of a line by its flat position.

The set is taken from a parameterised bit range of the address. The full line address is stored as the tag. Data storage, the coherence protocol that decides permission changes, and all accounting stay outside the block.

Top module: `cache_tag_dir`

## Requirements
- R1: A request with `reqValid` high gets exactly one response cycle, with `respValid` high, on the next clock. The set is `reqAddr[INDEX_LO +: log2(SETS)]` with SETS = CACHE_BYTES / WAYS / LINE_BYTES, so lines in different sets never interact.
- R2: Permission codes on `reqPerm` are 0 not-present, 1 invalid, 2 read-only, 3 read-write and 4 busy. A line counts as present only when it is occupied, its stored address equals `reqAddr`, and its permission is not 0.
- R3: Load (op 1) and fetch (op 2) hit on a present read-only or read-write line. Store (op 3) hits only on read-write. On a present line `respWayOH` marks that line, even when the hit flag is low.
- R4: An access that finds a present line makes it most recent in its set, even if the permission check fails. An access that finds no present line leaves the order unchanged.
- R5: Availability (op 5) hits when some way of the set holds the address (any permission), is empty, or is not-present. `respWayOH` is zero.
- R6: Allocation (op 6) fills the lowest-numbered empty or not-present way and reports it one-hot. It stores the address with permission invalid and lock owner all-ones, empties any stale not-present copy of the address, and updates the order only when `reqTouch` is high.
- R7: Allocating an address that is already present, or allocating into a set with no free way, raises `respErr` and changes no state.
- R8: Deallocation (op 7) empties the present way and reports it. With no present line it raises `respErr`.
- R9: Probe (op 8) returns the least recently used way of the set and its stored address in `respAddr`. When space is available it raises `respErr` instead.
- R10: Lock set (op 9) stores `reqCtx` in the present line and lock clear (op 10) stores all-ones. Lock test (op 11) hits only when the stored owner equals `reqCtx`. Each of the three raises `respErr` with no present line.
- R11: Permission write (op 12) stores `reqPerm` into the way whose address matches, whatever its permission, and reports it. Match lookup (op 14) hits on and reports such a way. Both ignore the permission, and with no such way op 12 errors and op 14 misses.
- R12: Indexed read (op 13) takes set = `reqIdx / WAYS` and way = `reqIdx % WAYS`. It returns that line's address with hit high, or zero with hit low if the line is empty, invalid or not-present.
- R13: Presence (op 4) hits on and reports a present line. Op codes 0 and 15 raise `respErr`. Outside a response cycle all response outputs are zero, and `respAddr` is zero except for probe and indexed read.
- R14: After reset every way is empty and the order in each set runs from way 0 (most recent) to way WAYS-1 (least recent).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 4 | Operation code |
| reqAddr | input | ADDR_W | Line-aligned address |
| reqTouch | input | 1 | Update order on allocation |
| reqCtx | input | CTX_W | Lock context |
| reqPerm | input | 3 | Permission for op 12 |
| reqIdx | input | log2(SETS*WAYS) | Flat line index for op 13 |
| respValid | output | 1 | Response strobe |
| respHit | output | 1 | Operation result |
| respErr | output | 1 | Illegal request |
| respWayOH | output | WAYS | Affected way, one-hot |
| respAddr | output | ADDR_W | Probe victim or indexed line address |

## Verification
The bench targets the replacement order. It probes after touched and untouched allocations and after an access that fails its permission check. A design that skipped the touch on a denied access, or touched on a plain miss, would name the wrong victim. It also allocates over a not-present line, fills a set and retries, and re-allocates a deallocated way that held a lock. A wrong design would then pick the wrong way, overwrite a line it should refuse, or leave the old owner in place. The ignore-permission paths are checked against the normal lookup, because a design that confuses the two would report a not-present line as found.

// File: rtl/cache_tag_dir_pkg.sv
package cache_tag_dir_pkg;

  typedef enum logic [2:0] {
    PERM_NP   = 3'd0,
    PERM_INV  = 3'd1,
    PERM_RO   = 3'd2,
    PERM_RW   = 3'd3,
    PERM_BUSY = 3'd4
  } perm_e;

  typedef enum logic [3:0] {
    OP_BAD0    = 4'd0,
    OP_LOAD    = 4'd1,
    OP_IFETCH  = 4'd2,
    OP_STORE   = 4'd3,
    OP_PRESENT = 4'd4,
    OP_AVAIL   = 4'd5,
    OP_ALLOC   = 4'd6,
    OP_DEALLOC = 4'd7,
    OP_PROBE   = 4'd8,
    OP_LOCKSET = 4'd9,
    OP_LOCKCLR = 4'd10,
    OP_LOCKTST = 4'd11,
    OP_SETPERM = 4'd12,
    OP_READIDX = 4'd13,
    OP_LOOKANY = 4'd14,
    OP_BAD15   = 4'd15
  } op_e;

  // Write strobes from control to the datapath; target way travels beside it.
  typedef struct packed {
    logic alloc;
    logic dealloc;
    logic lockWr;
    logic lockClr;
    logic permWr;
    logic touch;
  } dirStrobe_t;

endpackage

// File: rtl/cache_tag_dir_dp.sv
module cache_tag_dir_dp
  import cache_tag_dir_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  parameter int INDEX_LO = 4,
  parameter int CTX_W    = 4,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int IDX_W   = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic [2:0]        reqPerm,
  input  dirStrobe_t        stb,
  input  logic [WAYS-1:0]   tgtOH,
  output logic [WAYS-1:0]   matchAny,
  output logic [WAYS-1:0]   presentV,
  output logic [WAYS-1:0]   freeV,
  output logic [WAYS-1:0]   victimOH,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [2:0]        hitPerm,
  output logic [CTX_W-1:0]  hitLock,
  output logic [ADDR_W-1:0] idxAddr,
  output logic              idxLive
);

  logic [SET_W-1:0]  setIdx;
  logic [SET_W-1:0]  idxSet;
  logic [WAY_W-1:0]  idxWay;
  logic [WAY_W-1:0]  touchAge;

  logic              occQ  [SETS][WAYS];
  logic [ADDR_W-1:0] tagQ  [SETS][WAYS];
  logic [2:0]        permQ [SETS][WAYS];
  logic [CTX_W-1:0]  lockQ [SETS][WAYS];
  logic [WAY_W-1:0]  ageQ  [SETS][WAYS];

  assign setIdx = reqAddr[INDEX_LO +: SET_W];
  assign idxSet = reqIdx[IDX_W-1:WAY_W];
  assign idxWay = reqIdx[WAY_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign matchAny[w] = occQ[setIdx][w] && (tagQ[setIdx][w] == reqAddr);
    assign presentV[w] = matchAny[w] && (permQ[setIdx][w] != PERM_NP);
    assign freeV[w]    = !occQ[setIdx][w] || (permQ[setIdx][w] == PERM_NP);
    assign victimOH[w] = (ageQ[setIdx][w] == WAY_W'(WAYS - 1));
  end

  always_comb begin
    hitPerm    = '0;
    hitLock    = '0;
    victimAddr = '0;
    touchAge   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (matchAny[w]) begin
        hitPerm = hitPerm | permQ[setIdx][w];
        hitLock = hitLock | lockQ[setIdx][w];
      end
      if (victimOH[w]) victimAddr = victimAddr | tagQ[setIdx][w];
      if (tgtOH[w])    touchAge   = touchAge | ageQ[setIdx][w];
    end
  end

  assign idxLive = occQ[idxSet][idxWay] &&
                   (permQ[idxSet][idxWay] != PERM_NP) &&
                   (permQ[idxSet][idxWay] != PERM_INV);
  assign idxAddr = tagQ[idxSet][idxWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          occQ[s][w]  <= 1'b0;
          tagQ[s][w]  <= '0;
          permQ[s][w] <= PERM_NP;
          lockQ[s][w] <= '1;
          ageQ[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (tgtOH[w]) begin
          if (stb.alloc) begin
            occQ[setIdx][w]  <= 1'b1;
            tagQ[setIdx][w]  <= reqAddr;
            permQ[setIdx][w] <= PERM_INV;
            lockQ[setIdx][w] <= '1;
          end
          if (stb.dealloc) occQ[setIdx][w]  <= 1'b0;
          if (stb.lockWr)  lockQ[setIdx][w] <= reqCtx;
          if (stb.lockClr) lockQ[setIdx][w] <= '1;
          if (stb.permWr)  permQ[setIdx][w] <= reqPerm;
        end else if (stb.alloc && matchAny[w]) begin
          occQ[setIdx][w] <= 1'b0;
        end
        if (stb.touch) begin
          if (tgtOH[w])
            ageQ[setIdx][w] <= '0;
          else if (ageQ[setIdx][w] < touchAge)
            ageQ[setIdx][w] <= ageQ[setIdx][w] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cache_tag_dir_ctrl.sv
module cache_tag_dir_ctrl
  import cache_tag_dir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAYS   = 4,
  parameter int CTX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic              reqTouch,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic [WAYS-1:0]   matchAny,
  input  logic [WAYS-1:0]   presentV,
  input  logic [WAYS-1:0]   freeV,
  input  logic [WAYS-1:0]   victimOH,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [2:0]        hitPerm,
  input  logic [CTX_W-1:0]  hitLock,
  input  logic [ADDR_W-1:0] idxAddr,
  input  logic              idxLive,
  output dirStrobe_t        stb,
  output logic [WAYS-1:0]   tgtOH,
  output logic              respValid,
  output logic              respHit,
  output logic              respErr,
  output logic [WAYS-1:0]   respWayOH,
  output logic [ADDR_W-1:0] respAddr
);

  logic              anyPresent, anyMatch, anyFree, spaceOk;
  logic [WAYS-1:0]   lowFree;
  logic              nHit, nErr;
  logic [WAYS-1:0]   nWay;
  logic [ADDR_W-1:0] nAddr;

  assign anyPresent = |presentV;
  assign anyMatch   = |matchAny;
  assign anyFree    = |freeV;
  assign spaceOk    = anyMatch || anyFree;
  assign lowFree    = freeV & (~freeV + 1'b1);

  always_comb begin
    stb   = '0;
    tgtOH = '0;
    nHit  = 1'b0;
    nErr  = 1'b0;
    nWay  = '0;
    nAddr = '0;
    if (reqValid) begin
      case (op_e'(reqOp))
        OP_LOAD, OP_IFETCH, OP_STORE: begin
          nWay      = presentV;
          tgtOH     = presentV;
          stb.touch = anyPresent;
          if (op_e'(reqOp) == OP_STORE)
            nHit = anyPresent && (hitPerm == PERM_RW);
          else
            nHit = anyPresent && (hitPerm == PERM_RW || hitPerm == PERM_RO);
        end
        OP_PRESENT: begin
          nHit = anyPresent;
          nWay = presentV;
        end
        OP_AVAIL: nHit = spaceOk;
        OP_ALLOC: begin
          if (anyPresent || !anyFree) nErr = 1'b1;
          else begin
            stb.alloc = 1'b1;
            stb.touch = reqTouch;
            tgtOH     = lowFree;
            nWay      = lowFree;
            nHit      = 1'b1;
          end
        end
        OP_DEALLOC, OP_LOCKSET, OP_LOCKCLR, OP_LOCKTST: begin
          if (!anyPresent) nErr = 1'b1;
          else begin
            tgtOH       = presentV;
            nWay        = presentV;
            stb.dealloc = (op_e'(reqOp) == OP_DEALLOC);
            stb.lockWr  = (op_e'(reqOp) == OP_LOCKSET);
            stb.lockClr = (op_e'(reqOp) == OP_LOCKCLR);
            nHit = (op_e'(reqOp) == OP_LOCKTST) ? (hitLock == reqCtx) : 1'b1;
          end
        end
        OP_PROBE: begin
          if (spaceOk) nErr = 1'b1;
          else begin
            nHit  = 1'b1;
            nWay  = victimOH;
            nAddr = victimAddr;
          end
        end
        OP_SETPERM: begin
          if (!anyMatch) nErr = 1'b1;
          else begin
            stb.permWr = 1'b1;
            tgtOH      = matchAny;
            nWay       = matchAny;
            nHit       = 1'b1;
          end
        end
        OP_READIDX: begin
          nHit  = idxLive;
          nAddr = idxLive ? idxAddr : '0;
        end
        OP_LOOKANY: begin
          nHit = anyMatch;
          nWay = matchAny;
        end
        default: nErr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respErr   <= 1'b0;
      respWayOH <= '0;
      respAddr  <= '0;
    end else begin
      respValid <= reqValid;
      respHit   <= nHit;
      respErr   <= nErr;
      respWayOH <= nWay;
      respAddr  <= nAddr;
    end
  end

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import cache_tag_dir_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 256,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 4,
  parameter int INDEX_LO    = 4,
  parameter int CTX_W       = 4,
  localparam int SETS       = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int IDX_W      = $clog2(SETS) + $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqTouch,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic [2:0]        reqPerm,
  input  logic [IDX_W-1:0]  reqIdx,
  output logic              respValid,
  output logic              respHit,
  output logic              respErr,
  output logic [WAYS-1:0]   respWayOH,
  output logic [ADDR_W-1:0] respAddr
);

  dirStrobe_t        stb;
  logic [WAYS-1:0]   tgtOH, matchAny, presentV, freeV, victimOH;
  logic [ADDR_W-1:0] victimAddr, idxAddr;
  logic [2:0]        hitPerm;
  logic [CTX_W-1:0]  hitLock;
  logic              idxLive;

  cache_tag_dir_dp #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
    .INDEX_LO(INDEX_LO), .CTX_W(CTX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqIdx(reqIdx),
    .reqCtx(reqCtx), .reqPerm(reqPerm), .stb(stb), .tgtOH(tgtOH),
    .matchAny(matchAny), .presentV(presentV), .freeV(freeV),
    .victimOH(victimOH), .victimAddr(victimAddr), .hitPerm(hitPerm),
    .hitLock(hitLock), .idxAddr(idxAddr), .idxLive(idxLive)
  );

  cache_tag_dir_ctrl #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .CTX_W(CTX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqTouch(reqTouch), .reqCtx(reqCtx), .matchAny(matchAny),
    .presentV(presentV), .freeV(freeV), .victimOH(victimOH),
    .victimAddr(victimAddr), .hitPerm(hitPerm), .hitLock(hitLock),
    .idxAddr(idxAddr), .idxLive(idxLive), .stb(stb), .tgtOH(tgtOH),
    .respValid(respValid), .respHit(respHit), .respErr(respErr),
    .respWayOH(respWayOH), .respAddr(respAddr)
  );

endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk
  import cache_tag_dir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [3:0]        reqOp,
  input logic              respValid,
  input logic              respHit,
  input logic              respErr,
  input logic [WAYS-1:0]   respWayOH,
  input logic [ADDR_W-1:0] respAddr
);

  a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  a_r13_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (respWayOH == '0 && !respHit && !respErr && respAddr == '0));

  a_r3_way_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(respWayOH));

  a_r7_hit_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(respHit && respErr));

  a_r6_alloc_outcome: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_ALLOC) |=> (respErr != ($countones(respWayOH) == 1)));

  a_r9_probe_outcome: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_PROBE) |=>
      (respErr || (respHit && $countones(respWayOH) == 1)));

  a_r5_avail_no_way: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_AVAIL) |=> (respWayOH == '0));

endmodule

bind cache_tag_dir cache_tag_dir_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .respValid(respValid), .respHit(respHit), .respErr(respErr),
  .respWayOH(respWayOH), .respAddr(respAddr)
);

// File: tb/cache_tag_dir_tb.sv
module cache_tag_dir_tb;

  localparam int NV = 54;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqOp = '0;
  logic [15:0] reqAddr = '0;
  logic        reqTouch = 1'b0;
  logic [3:0]  reqCtx = '0;
  logic [2:0]  reqPerm = '0;
  logic [3:0]  reqIdx = '0;
  logic        respValid, respHit, respErr;
  logic [3:0]  respWayOH;
  logic [15:0] respAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  cache_tag_dir u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqTouch(reqTouch), .reqCtx(reqCtx),
    .reqPerm(reqPerm), .reqIdx(reqIdx), .respValid(respValid),
    .respHit(respHit), .respErr(respErr), .respWayOH(respWayOH),
    .respAddr(respAddr)
  );

  // Vector: req, op, addr, touch, ctx, perm, idx, expHit, expErr, expWay, expAddr
  function automatic logic [57:0] mk(int r, int op, int a, int t, int c, int p,
                                     int ix, int h, int e, int w, int ea);
    return {4'(r), 4'(op), 16'(a), 1'(t), 4'(c), 3'(p), 4'(ix),
            1'(h), 1'(e), 4'(w), 16'(ea)};
  endfunction

  localparam logic [57:0] VEC [NV] = '{
    mk(13, 4,'h040,0,0,0,0, 0,0,4'h0,0),       // R13 absent
    mk( 5, 5,'h040,0,0,0,0, 1,0,4'h0,0),       // R5 empty set
    mk( 6, 6,'h040,1,0,0,0, 1,0,4'h1,0),       // R6 way0
    mk( 7, 6,'h040,0,0,0,0, 0,1,4'h0,0),       // R7 already present
    mk( 3, 1,'h040,0,0,0,0, 0,0,4'h1,0),       // R3 load on invalid
    mk(11,12,'h040,0,0,2,0, 1,0,4'h1,0),       // R11 -> read-only
    mk( 3, 1,'h040,0,0,0,0, 1,0,4'h1,0),       // R3 load RO
    mk( 3, 2,'h040,0,0,0,0, 1,0,4'h1,0),       // R3 fetch RO
    mk( 3, 3,'h040,0,0,0,0, 0,0,4'h1,0),       // R3 store RO fails
    mk(11,12,'h040,0,0,3,0, 1,0,4'h1,0),       // R11 -> read-write
    mk( 3, 3,'h040,0,0,0,0, 1,0,4'h1,0),       // R3 store RW
    mk( 6, 6,'h080,0,0,0,0, 1,0,4'h2,0),       // R6 way1 no touch
    mk( 6, 6,'h0C0,1,0,0,0, 1,0,4'h4,0),       // R6 way2 touch
    mk( 6, 6,'h100,0,0,0,0, 1,0,4'h8,0),       // R6 way3
    mk( 5, 5,'h140,0,0,0,0, 0,0,4'h0,0),       // R5 full set
    mk( 7, 6,'h140,0,0,0,0, 0,1,4'h0,0),       // R7 no space
    mk( 9, 8,'h140,0,0,0,0, 1,0,4'h8,'h100),   // R9 victim way3
    mk( 4, 1,'h100,0,0,0,0, 0,0,4'h8,0),       // R4 denied access touches
    mk( 4, 8,'h140,0,0,0,0, 1,0,4'h2,'h080),   // R4 victim now way1
    mk( 5, 5,'h080,0,0,0,0, 1,0,4'h0,0),       // R5 match
    mk(11,12,'h080,0,0,0,0, 1,0,4'h2,0),       // R11 -> not-present
    mk( 2, 4,'h080,0,0,0,0, 0,0,4'h0,0),       // R2 NP not found
    mk(11,14,'h080,0,0,0,0, 1,0,4'h2,0),       // R11 lookup ignores perm
    mk( 2, 1,'h080,0,0,0,0, 0,0,4'h0,0),       // R2 load miss, no touch
    mk( 5, 5,'h140,0,0,0,0, 1,0,4'h0,0),       // R5 NP way counts free
    mk( 9, 8,'h140,0,0,0,0, 0,1,4'h0,0),       // R9 probe with space
    mk( 6, 6,'h140,0,0,0,0, 1,0,4'h2,0),       // R6 reuse NP way1
    mk( 4, 8,'h180,0,0,0,0, 1,0,4'h2,'h140),   // R4 miss did not touch
    mk(10,11,'h0C0,0,5,0,0, 0,0,4'h4,0),       // R10 unlocked
    mk(10, 9,'h0C0,0,5,0,0, 1,0,4'h4,0),       // R10 set
    mk(10,11,'h0C0,0,5,0,0, 1,0,4'h4,0),       // R10 owner
    mk(10,11,'h0C0,0,6,0,0, 0,0,4'h4,0),       // R10 other ctx
    mk(10,10,'h0C0,0,0,0,0, 1,0,4'h4,0),       // R10 clear
    mk(10,11,'h0C0,0,5,0,0, 0,0,4'h4,0),       // R10 cleared
    mk(10,11,'h0C0,0,15,0,0,1,0,4'h4,0),       // R10 all-ones owner
    mk(10, 9,'h200,0,5,0,0, 0,1,4'h0,0),       // R10 absent
    mk(10, 9,'h0C0,0,5,0,0, 1,0,4'h4,0),       // R10 relock
    mk(12,13,'h000,0,0,0,0, 1,0,4'h0,'h040),   // R12 RW line
    mk(12,13,'h000,0,0,0,1, 0,0,4'h0,0),       // R12 invalid line
    mk(12,13,'h000,0,0,0,5, 0,0,4'h0,0),       // R12 empty line
    mk( 8, 7,'h0C0,0,0,0,0, 1,0,4'h4,0),       // R8 dealloc
    mk( 8, 4,'h0C0,0,0,0,0, 0,0,4'h0,0),       // R8 gone
    mk( 8, 7,'h0C0,0,0,0,0, 0,1,4'h0,0),       // R8 again errs
    mk( 6, 6,'h240,0,0,0,0, 1,0,4'h4,0),       // R6 lowest free way2
    mk( 6,11,'h240,0,5,0,0, 0,0,4'h4,0),       // R6 old lock dropped
    mk( 6,11,'h240,0,15,0,0,1,0,4'h4,0),       // R6 lock all-ones
    mk( 1, 6,'h010,1,0,0,0, 1,0,4'h1,0),       // R1 set1 independent
    mk( 1, 4,'h050,0,0,0,0, 0,0,4'h0,0),       // R1 set1 absent
    mk( 3, 3,'h010,0,0,0,0, 0,0,4'h1,0),       // R3 store invalid
    mk(11,12,'h010,0,0,4,0, 1,0,4'h1,0),       // R11 -> busy
    mk( 3, 1,'h010,0,0,0,0, 0,0,4'h1,0),       // R3 load busy fails
    mk(13, 0,'h040,0,0,0,0, 0,1,4'h0,0),       // R13 op 0
    mk(13,15,'h040,0,0,0,0, 0,1,4'h0,0),       // R13 op 15
    mk(13, 4,'h040,0,0,0,0, 1,0,4'h1,0)        // R13 present
  };

  task automatic issue(input logic [3:0] op, input logic [15:0] a, input logic t,
                       input logic [3:0] c, input logic [2:0] p, input logic [3:0] ix);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqTouch = t;
    reqCtx = c; reqPerm = p; reqIdx = ix;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect_resp(input int r, input logic h, input logic e,
                             input logic [3:0] w, input logic [15:0] ea);
    nChecks++;
    if (!(respValid === 1'b1 && respHit === h && respErr === e &&
          respWayOH === w && respAddr === ea)) begin
      nFails++;
      $display("FAIL R%0d: got v=%b hit=%b err=%b way=%b addr=%h, exp v=1 hit=%b err=%b way=%b addr=%h",
               r, respValid, respHit, respErr, respWayOH, respAddr, h, e, w, ea);
    end
  endtask

  initial begin
    #(8 * 20000);
    nFails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: no response out of reset
    nChecks++;
    if (respValid !== 1'b0 || respHit !== 1'b0 || respErr !== 1'b0) begin
      nFails++;
      $display("FAIL R14: got v=%b hit=%b err=%b, exp 0 0 0", respValid, respHit, respErr);
    end
    rstN = 1'b1;
    // R14: every way empty after reset
    for (int i = 0; i < 16; i++) begin
      issue(4'd13, 16'h0, 1'b0, 4'd0, 3'd0, 4'(i));
      expect_resp(14, 1'b0, 1'b0, 4'h0, 16'h0);
    end
    // R9: probe on an empty set errs
    issue(4'd8, 16'h0040, 1'b0, 4'd0, 3'd0, 4'd0);
    expect_resp(9, 1'b0, 1'b1, 4'h0, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      v = VEC[i];
      issue(v[53:50], v[49:34], v[33], v[32:29], v[28:26], v[25:22]);
      expect_resp(int'(v[57:54]), v[21], v[20], v[19:16], v[15:0]);
    end

    // R1: response lasts one cycle
    @(negedge clk);
    nChecks++;
    if (respValid !== 1'b0) begin
      nFails++;
      $display("FAIL R1: got respValid=%b, exp 0", respValid);
    end

    // R14: reset clears contents and restores way order
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    issue(4'd4, 16'h0040, 1'b0, 4'd0, 3'd0, 4'd0);
    expect_resp(14, 1'b0, 1'b0, 4'h0, 16'h0);
    for (int i = 0; i < 4; i++) begin
      issue(4'd6, 16'(16'h0040 * (i + 1)), 1'b0, 4'd0, 3'd0, 4'd0);
      expect_resp(14, 1'b1, 1'b0, 4'(1 << i), 16'h0);
    end
    issue(4'd8, 16'h0140, 1'b0, 4'd0, 3'd0, 4'd0);
    expect_resp(14, 1'b1, 1'b0, 4'h8, 16'h0100);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule